// File: doc/BRIEF.md
# Wake Event Controller

This block decides when a device that is powered down may wake its host. It takes three detected events: a magic-packet match, a wake-frame match and a link coming up. An event that its enables allow sets a sticky status flag. While that flag is set, and the device enables permit it, the block requests a wake on three channels:

- an open-drain wake pin, modelled as a pull-low enable;
- a power-management message request, used in the powered states D0 to D3hot;
- a beacon request, used in D3cold.

Software reaches a small configuration space through a write port and a combinational read port. The space holds a device wake enable, two per-source enables, the host-side wake enable, the status flag and a capability word. The capability word holds a per-power-state support mask and can be trimmed when auxiliary power is absent. The power state is loaded from outside. A bus reset taken in D3cold returns the power state to D0.

Top module: `wake_event_ctrl`

## Requirements
- R1: After `rst_n` is released, all enable bits, the status flag and the power state read 0 (state D0), and `wake_oe_o`, `msg_req_o` and `beacon_req_o` are 0.
- R2: The status flag (PMCSR read, bit 15) is set one cycle after an event whose source is enabled and `evt_i` is asserted. The device enable (CFG1 bit 0) must be 1 for every source. In addition, a magic event (`evt_i[0]`) needs CFG3 bit 5, a link event (`evt_i[2]`) needs CFG3 bit 4, and a wake-frame event (`evt_i[1]`) needs nothing further. An event that is not enabled leaves the flag unchanged.
- R3: A write to PMCSR (select 2) with bit 15 set clears the status flag. The same write with bit 15 at 0 leaves the flag as it was. An enabled event in the same cycle as a clearing write wins, and the flag stays 1.
- R4: `wake_oe_o` is 1 exactly when the status flag, the host wake enable (PMCSR bit 8), the device enable, and the support bit for the current power state are all 1.
- R5: The support bits are capability bits 11 to 15, for D0, D1, D2, D3hot and D3cold in that order. The power state encodings are D0=0, D1=1, D2=2, D3hot=3 and D3cold=4. Encodings 5 to 7 never permit a wake.
- R6: The capability word reads at select 3. When `aux_pwr_i` is 0, its bit 15 and bits 8 to 6 read as 0, so D3cold gives no wake. Otherwise it reads as the `PMC_INIT` parameter.
- R7: `msg_req_o` follows the condition of R4 in states 0 to 3. `beacon_req_o` follows it in state 4. Both are 0 while `isolate_n` is 0, and `wake_oe_o` is unaffected by `isolate_n`.
- R8: Configuration writes take effect at the next edge. They are ignored while `isolate_n` is 0. Events still set the status flag while `isolate_n` is 0.
- R9: A cycle with `bus_rst_i` = 1 in state 4 moves the state to 0. In any other state it leaves the state unchanged. Otherwise, `pstate_ld_i` loads `pstate_i`, and the bus reset takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| isolate_n | input | 1 | Active-low isolation of the bus side |
| aux_pwr_i | input | 1 | Auxiliary power present |
| evt_i | input | 3 | Source events: 0 magic, 1 wake frame, 2 link up |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write select: 0 CFG1, 1 CFG3, 2 PMCSR, 3 capability (read-only) |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rsel_i | input | 2 | Read select, same encoding |
| cfg_rdata_o | output | 16 | Read data for the selected register |
| pstate_ld_i | input | 1 | Load strobe for the power state |
| pstate_i | input | 3 | New power state |
| bus_rst_i | input | 1 | Bus-side reset event |
| pstate_o | output | 3 | Current power state |
| wake_oe_o | output | 1 | Wake pin pull-low enable |
| msg_req_o | output | 1 | Power-management message request |
| beacon_req_o | output | 1 | Beacon request |

## Verification
Faults in the sticky flag or in an enable register show on the wake outputs and on the read port in the cycle after the event or write that should have changed them. A missed clear leaves `wake_oe_o` asserted, and a spurious set raises it without cause. A wrong support-mask index or aux trim shows only in particular power states, so the states are loaded at random, including the unused encodings. A wrong isolation gate shows as a message or beacon request during isolation, or as a lost write.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int CFG_W = 16;
  localparam int PS_W  = 3;
  localparam int N_PS  = 5;
  localparam int N_SRC = 3;

  localparam logic [PS_W-1:0] PS_D0     = 3'd0;
  localparam logic [PS_W-1:0] PS_D3COLD = 3'd4;

  localparam logic [1:0] SEL_CFG1  = 2'd0;
  localparam logic [1:0] SEL_CFG3  = 2'd1;
  localparam logic [1:0] SEL_PMCSR = 2'd2;
  localparam logic [1:0] SEL_PMC   = 2'd3;

  localparam int DEV_EN_BIT   = 0;
  localparam int LINK_EN_BIT  = 4;
  localparam int MAGIC_EN_BIT = 5;
  localparam int PME_EN_BIT   = 8;
  localparam int STAT_BIT     = 15;
  localparam int SUPP_LSB     = 11;

  localparam logic [CFG_W-1:0] AUX_DEP_MASK = 16'h81C0;

  localparam int SRC_MAGIC = 0;
  localparam int SRC_FRAME = 1;
  localparam int SRC_LINK  = 2;

  typedef struct packed {
    logic dev_en;
    logic link_en;
    logic magic_en;
    logic pme_en;
  } cfg_t;
endpackage

// File: rtl/wake_rst_sync.sv
module wake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
  import wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             isolate_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             set_req,
  output cfg_t             cfg_q,
  output logic             status_q
);
  cfg_t cfg_d;
  logic status_d;
  logic wr_ok, clr_req, upd;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[14:9], wr_data[7:6], wr_data[3:1]};

  always_comb begin
    cfg_d    = cfg_q;
    status_d = status_q;
    wr_ok    = wr_en & isolate_n;
    clr_req  = wr_ok & (wr_sel == SEL_PMCSR) & wr_data[STAT_BIT];
    if (wr_ok) begin
      case (wr_sel)
        SEL_CFG1: cfg_d.dev_en = wr_data[DEV_EN_BIT];
        SEL_CFG3: begin
          cfg_d.link_en  = wr_data[LINK_EN_BIT];
          cfg_d.magic_en = wr_data[MAGIC_EN_BIT];
        end
        SEL_PMCSR: cfg_d.pme_en = wr_data[PME_EN_BIT];
        default: ;
      endcase
    end
    if (set_req)      status_d = 1'b1;
    else if (clr_req) status_d = 1'b0;
    upd = wr_ok | set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      status_q <= 1'b0;
    end else if (upd) begin
      cfg_q    <= cfg_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/wake_pstate.sv
module wake_pstate
  import wake_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [PS_W-1:0] ps_in,
  input  logic            bus_rst,
  output logic [PS_W-1:0] ps_q
);
  logic [PS_W-1:0] ps_d;
  logic            upd;

  always_comb begin
    ps_d = ps_q;
    upd  = 1'b0;
    if (bus_rst && ps_q == PS_D3COLD) begin
      ps_d = PS_D0;
      upd  = 1'b1;
    end else if (ld) begin
      ps_d = ps_in;
      upd  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ps_q <= PS_D0;
    else if (upd) ps_q <= ps_d;
  end
endmodule

// File: rtl/wake_gate.sv
module wake_gate
  import wake_pkg::*;
#(
  parameter logic [CFG_W-1:0] PMC_INIT = 16'hF9C3
) (
  input  cfg_t             cfg,
  input  logic             status,
  input  logic [N_SRC-1:0] evt,
  input  logic [PS_W-1:0]  pstate,
  input  logic             aux_pwr,
  input  logic             isolate_n,
  output logic             set_req,
  output logic [CFG_W-1:0] pmc_eff,
  output logic             wake_oe,
  output logic             msg_req,
  output logic             beacon_req
);
  logic [N_SRC-1:0] src_en;
  logic [N_PS-1:0]  supp_vec;
  logic             ps_ok, armed;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i == SRC_MAGIC) begin : g_magic
      assign src_en[i] = cfg.magic_en;
    end else if (i == SRC_LINK) begin : g_link
      assign src_en[i] = cfg.link_en;
    end else begin : g_free
      assign src_en[i] = 1'b1;
    end
  end

  always_comb begin
    set_req    = cfg.dev_en & (|(evt & src_en));
    pmc_eff    = aux_pwr ? PMC_INIT : (PMC_INIT & ~AUX_DEP_MASK);
    supp_vec   = pmc_eff[SUPP_LSB +: N_PS];
    ps_ok      = (pstate <= PS_D3COLD) ? supp_vec[pstate] : 1'b0;
    armed      = status & cfg.pme_en & cfg.dev_en & ps_ok;
    wake_oe    = armed;
    msg_req    = armed & isolate_n & (pstate != PS_D3COLD);
    beacon_req = armed & isolate_n & (pstate == PS_D3COLD);
  end
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_pkg::*;
#(
  parameter logic [15:0] PMC_INIT = 16'hF9C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        isolate_n,
  input  logic        aux_pwr_i,
  input  logic [2:0]  evt_i,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [15:0] cfg_wdata_i,
  input  logic [1:0]  cfg_rsel_i,
  output logic [15:0] cfg_rdata_o,
  input  logic        pstate_ld_i,
  input  logic [2:0]  pstate_i,
  input  logic        bus_rst_i,
  output logic [2:0]  pstate_o,
  output logic        wake_oe_o,
  output logic        msg_req_o,
  output logic        beacon_req_o
);
  logic             rst_s_n;
  cfg_t             cfg_q;
  logic             status_q;
  logic             set_req;
  logic [PS_W-1:0]  pstate_q;
  logic [CFG_W-1:0] pmc_eff;

  wake_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  wake_cfg_regs regs_i (
    .clk(clk), .rst_n(rst_s_n), .isolate_n(isolate_n),
    .wr_en(cfg_we_i), .wr_sel(cfg_sel_i), .wr_data(cfg_wdata_i),
    .set_req(set_req), .cfg_q(cfg_q), .status_q(status_q)
  );

  wake_pstate ps_i (
    .clk(clk), .rst_n(rst_s_n), .ld(pstate_ld_i), .ps_in(pstate_i),
    .bus_rst(bus_rst_i), .ps_q(pstate_q)
  );

  wake_gate #(.PMC_INIT(PMC_INIT)) gate_i (
    .cfg(cfg_q), .status(status_q), .evt(evt_i), .pstate(pstate_q),
    .aux_pwr(aux_pwr_i), .isolate_n(isolate_n), .set_req(set_req),
    .pmc_eff(pmc_eff), .wake_oe(wake_oe_o), .msg_req(msg_req_o),
    .beacon_req(beacon_req_o)
  );

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_rsel_i)
      SEL_CFG1: cfg_rdata_o[DEV_EN_BIT] = cfg_q.dev_en;
      SEL_CFG3: begin
        cfg_rdata_o[LINK_EN_BIT]  = cfg_q.link_en;
        cfg_rdata_o[MAGIC_EN_BIT] = cfg_q.magic_en;
      end
      SEL_PMCSR: begin
        cfg_rdata_o[PME_EN_BIT] = cfg_q.pme_en;
        cfg_rdata_o[STAT_BIT]   = status_q;
      end
      default: cfg_rdata_o = pmc_eff;
    endcase
  end

  assign pstate_o = pstate_q;
endmodule

// File: rtl/wake_event_ctrl_chk.sv
module wake_event_ctrl_chk
  import wake_pkg::*;
(
  input logic        clk,
  input logic        rst_s_n,
  input logic        isolate_n,
  input logic        cfg_we_i,
  input logic [1:0]  cfg_sel_i,
  input logic [15:0] cfg_wdata_i,
  input logic        bus_rst_i,
  input logic        wake_oe_o,
  input logic        msg_req_o,
  input logic        beacon_req_o,
  input logic        status_q,
  input cfg_t        cfg_q,
  input logic [2:0]  pstate_q,
  input logic        set_req
);
  logic unused_chk_bits;
  assign unused_chk_bits = ^cfg_wdata_i[14:0];

  // R4
  pin_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    wake_oe_o |-> (status_q && cfg_q.pme_en && cfg_q.dev_en));

  // R7
  isolate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !isolate_n |-> (!msg_req_o && !beacon_req_o));

  // R7
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({msg_req_o, beacon_req_o}));

  // R3
  clear_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(status_q) |-> $past(cfg_we_i && isolate_n && cfg_sel_i == SEL_PMCSR && cfg_wdata_i[STAT_BIT]));

  // R2
  set_by_event_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(status_q) |-> $past(set_req));

  // R8
  isolate_no_write_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !isolate_n |=> $stable(cfg_q));

  // R9
  cold_reset_d0_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rst_i && pstate_q == PS_D3COLD) |=> (pstate_q == PS_D0));
endmodule

bind wake_event_ctrl wake_event_ctrl_chk chk_i (
  .clk(clk), .rst_s_n(rst_s_n), .isolate_n(isolate_n), .cfg_we_i(cfg_we_i),
  .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .bus_rst_i(bus_rst_i),
  .wake_oe_o(wake_oe_o), .msg_req_o(msg_req_o), .beacon_req_o(beacon_req_o),
  .status_q(status_q), .cfg_q(cfg_q), .pstate_q(pstate_q), .set_req(set_req)
);

// File: tb/wake_event_ctrl_tb_top.sv
module wake_event_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PMC_P = 16'hB1C3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        isolate_n, aux_pwr_i, cfg_we_i, pstate_ld_i, bus_rst_i;
  logic [2:0]  evt_i, pstate_i, pstate_o;
  logic [1:0]  cfg_sel_i, cfg_rsel_i;
  logic [15:0] cfg_wdata_i, cfg_rdata_o;
  logic        wake_oe_o, msg_req_o, beacon_req_o;

  int errors = 0;
  int checks = 0;

  // model state
  logic m_dev, m_link, m_magic, m_pme, m_stat;
  logic [2:0] m_ps;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_event_ctrl #(.PMC_INIT(PMC_P)) dut_i (
    .clk(clk), .rst_n(rst_n), .isolate_n(isolate_n), .aux_pwr_i(aux_pwr_i),
    .evt_i(evt_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rsel_i(cfg_rsel_i), .cfg_rdata_o(cfg_rdata_o),
    .pstate_ld_i(pstate_ld_i), .pstate_i(pstate_i), .bus_rst_i(bus_rst_i),
    .pstate_o(pstate_o), .wake_oe_o(wake_oe_o), .msg_req_o(msg_req_o),
    .beacon_req_o(beacon_req_o)
  );

  function automatic logic [15:0] f_pmc(input logic aux);
    return aux ? PMC_P : (PMC_P & ~16'h81C0);
  endfunction

  function automatic logic f_armed(input logic aux);
    logic [15:0] p = f_pmc(aux);
    logic ok = (m_ps <= 3'd4) ? p[11 + int'(m_ps)] : 1'b0;
    return m_stat & m_pme & m_dev & ok;
  endfunction

  function automatic logic [15:0] f_rd(input logic [1:0] sel, input logic aux);
    logic [15:0] r = '0;
    case (sel)
      2'd0: r[0] = m_dev;
      2'd1: begin r[4] = m_link; r[5] = m_magic; end
      2'd2: begin r[8] = m_pme; r[15] = m_stat; end
      default: r = f_pmc(aux);
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] ev, input logic we, input logic [1:0] sel,
                      input logic [15:0] d, input logic iso, input logic ld,
                      input logic [2:0] ps, input logic brst, input logic aux,
                      input logic [1:0] rsel);
    logic a, set, clr, wok;
    @(negedge clk);
    evt_i = ev; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = d; isolate_n = iso;
    pstate_ld_i = ld; pstate_i = ps; bus_rst_i = brst; aux_pwr_i = aux; cfg_rsel_i = rsel;
    #1;
    a = f_armed(aux);
    chk("R4 wake pin", {15'b0, wake_oe_o}, {15'b0, a});
    chk("R7 message", {15'b0, msg_req_o}, {15'b0, a & iso & (m_ps != 3'd4)});
    chk("R7 beacon", {15'b0, beacon_req_o}, {15'b0, a & iso & (m_ps == 3'd4)});
    chk(rsel == 2'd3 ? "R6 capability" : (rsel == 2'd2 ? "R3 pmcsr" : "R8 cfg"),
        cfg_rdata_o, f_rd(rsel, aux));
    chk("R9 state", {13'b0, pstate_o}, {13'b0, m_ps});
    // advance model
    wok = we & iso;
    set = m_dev & ((ev[0] & m_magic) | ev[1] | (ev[2] & m_link));
    clr = wok & (sel == 2'd2) & d[15];
    if (wok) begin
      if (sel == 2'd0) m_dev = d[0];
      if (sel == 2'd1) begin m_link = d[4]; m_magic = d[5]; end
      if (sel == 2'd2) m_pme = d[8];
    end
    if (set) m_stat = 1'b1;
    else if (clr) m_stat = 1'b0;
    if (brst && m_ps == 3'd4) m_ps = 3'd0;
    else if (ld) m_ps = ps;
  endtask

  task automatic idle(input logic iso, input logic aux, input logic [1:0] rsel);
    step(3'b0, 1'b0, 2'd0, 16'h0, iso, 1'b0, 3'd0, 1'b0, aux, rsel);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    isolate_n = 1'b1; aux_pwr_i = 1'b1; evt_i = '0; cfg_we_i = 1'b0; cfg_sel_i = '0;
    cfg_wdata_i = '0; cfg_rsel_i = '0; pstate_ld_i = 1'b0; pstate_i = '0; bus_rst_i = 1'b0;
    m_dev = 0; m_link = 0; m_magic = 0; m_pme = 0; m_stat = 0; m_ps = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset view of every register
    for (int s = 0; s < 4; s++) idle(1'b1, 1'b1, 2'(s));
    // R2: events with device enable off do nothing
    step(3'b111, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    step(3'b000, 1'b1, 2'd0, 16'h0001, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd0);
    step(3'b000, 1'b1, 2'd2, 16'h0100, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    // R2: link and magic blocked without their enables
    step(3'b101, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    // R5: frame event in D0 (unsupported) sets status but no wake
    step(3'b010, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    // R5: D1 supported -> message
    step(3'b000, 1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    // R3: writing 0 to status keeps it
    step(3'b000, 1'b1, 2'd2, 16'h0100, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    // R7: D3cold -> beacon; isolate drops beacon, pin stays
    step(3'b000, 1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 3'd4, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    idle(1'b0, 1'b1, 2'd2);
    // R8: write during isolation ignored
    step(3'b000, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 2'd0);
    idle(1'b1, 1'b1, 2'd0);
    // R6: aux absent removes D3cold support
    idle(1'b1, 1'b0, 2'd3);
    // R9: bus reset in D3cold returns to D0; load then reset in D2 keeps D2
    step(3'b000, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    step(3'b000, 1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b1, 2'd2);
    step(3'b000, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 2'd2);
    // R3: clear with event in same cycle -> stays set; then plain clear
    step(3'b010, 1'b1, 2'd2, 16'h8100, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    step(3'b000, 1'b1, 2'd2, 16'h8100, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    // R5: unused encoding never wakes
    step(3'b010, 1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 3'd6, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    // R2: link enabled then link event
    step(3'b000, 1'b1, 2'd1, 16'h0010, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 2'd1);
    step(3'b100, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd2);
    idle(1'b1, 1'b1, 2'd2);
    // random mix over all requirements
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] ev;
      logic we, iso, ld, brst, aux;
      ev[0] = ($urandom % 5) == 0;
      ev[1] = ($urandom % 8) == 0;
      ev[2] = ($urandom % 5) == 0;
      we   = ($urandom % 3) == 0;
      iso  = ($urandom % 7) != 0;
      ld   = ($urandom % 10) == 0;
      brst = ($urandom % 15) == 0;
      aux  = ($urandom % 12) != 0;
      step(ev, we, 2'($urandom), 16'($urandom), iso, ld, 3'($urandom), brst, aux,
           2'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule